// File: doc/BRIEF.md
# Decoder Command Register Front-End

This block is the host-facing register front of a bitstream-decoding coprocessor. It decodes 32-bit and 64-bit host writes to a command register and a control register. It also assembles readback of the command, control and bit-pointer registers from its own state and from live status that the execution engine supplies. The decode engines themselves sit elsewhere; this block only classifies, dispatches and tracks commands.

Every accepted command word is latched as the current command. Two commands need no stream data. These are the buffer-clear and the threshold-set commands, and they complete immediately with a one-cycle interrupt. Every other known command raises a busy flag and a start pulse toward the engine. Busy stays high until the engine returns a completion strobe, at which point busy drops, the current command becomes all ones and the interrupt pulses.

The block also drives pulses to clear the input FIFO, to load or advance the bit pointer, and to soft-reset the engine. A control write can trigger that soft reset, and it remaps an illegal DC-precision code to a legal one.

Top module: `dcmd_frontend`

## Requirements
- R1: Only the low 8 address bits select a register, on both writes and reads. The command register is at 0x00, the control register at 0x10 and the bit-pointer register at 0x20. Any other offset reads zero, and writes to it have no effect.
- R2: After reset, busy, top-busy, data-busy and irq are low, the command register reads 0xFFFFFFFF, both thresholds are zero, and the control register reads zero when the live inputs are zero.
- R3: The opcode is command bits 31:28, and opcode 0 is buffer-clear. On the next cycle it pulses fifo_clear and bp_load, with bp_load_val equal to command bits 6:0. Busy, top-busy and data-busy are cleared, and irq pulses.
- R4: Opcode 9 is threshold-set. It loads threshold 0 from command bits 7:0 and threshold 1 from bits 23:16, pulses irq on the next cycle, and does not raise busy.
- R5: Opcodes 1 to 8 raise busy and cmd_start on the next cycle. Opcodes 1 to 5 also pulse bp_adv, with bp_adv_bits equal to command bits 5:0. Opcodes 1 and 2 set top-busy, and opcodes 3 and 4 set data-busy.
- R6: A write of a known opcode clears the end-of-data flag (control bit 14) and the start-code flag (control bit 15). Between command writes, these flags are set by the engine's eng_flag_end and eng_flag_start strobes.
- R7: While busy, an eng_done strobe clears busy, top-busy and data-busy, sets the command register to 0xFFFFFFFF and pulses irq on the next cycle. When idle, eng_done has no effect.
- R8: A narrow write to the control register stores bits 23:16 as the engine configuration. A DC-precision field (bits 17:16) of 3 is stored as 1.
- R9: A narrow control write with bit 30 set performs a soft reset on the next cycle. It pulses fifo_clear, soft_rst and bp_load with value 0, clears busy, top-busy, data-busy and both flags, and zeroes the configuration. It sets the command register to 0xFFFFFFFF.
- R10: The bit-pointer register reads the bit offset in bits 6:0, the FIFO count in bits 8+, and the fill pointer in bits 17:16.
- R11: The control register reads the FIFO count in bits 3:0, the coded-block pattern in bits 13:8, the flags in bits 14 and 15, the configuration in bits 23:16 and busy in bit 31.
- R12: A command write with an opcode of 10 to 15 is ignored. It leaves busy, irq, the flags, the command register and all pulses unchanged or low.
- R13: A wide (64-bit) write to the command register takes the low 32 data bits. A wide write to the control register is ignored.
- R14: irq is a single-cycle pulse per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_wide | input | 1 | Write is a 64-bit access |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 32 | Write data (low word of the access) |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Combinational read data |
| eng_done | input | 1 | Engine completion strobe |
| eng_flag_end | input | 1 | Engine end-of-data strobe |
| eng_flag_start | input | 1 | Engine start-code strobe |
| live_bp_off | input | 7 | Live bit offset |
| live_fifo_cnt | input | IFC_W | Live input FIFO count |
| live_fill_ptr | input | 2 | Live fill pointer |
| live_cbp | input | CBP_W | Live coded-block pattern |
| busy | output | 1 | Command in progress |
| top_busy | output | 1 | Block-decode command in progress |
| data_busy | output | 1 | Data-returning command in progress |
| irq | output | 1 | Completion interrupt pulse |
| cmd_start | output | 1 | Start pulse to the engine |
| cmd_word | output | 32 | Current command word |
| fifo_clear | output | 1 | Input FIFO clear pulse |
| bp_load | output | 1 | Bit-pointer load pulse |
| bp_load_val | output | 7 | Value to load into the bit offset |
| bp_adv | output | 1 | Bit-pointer advance pulse |
| bp_adv_bits | output | 6 | Bits to advance |
| soft_rst | output | 1 | Engine soft reset pulse |
| dec_cfg | output | 8 | Engine configuration byte |
| thresh0 | output | 8 | Threshold 0 |
| thresh1 | output | 8 | Threshold 1 |

## Verification
Every registered result is due exactly one clock edge after the write or strobe that causes it. This covers busy, irq, the FIFO, pointer and reset pulses, the thresholds and the command word. Readback is combinational from registered state and the live inputs, so a read settles within the same cycle. The bench drives inputs on the falling edge and checks them at the next falling edge, one rising edge later. It checks irq once more a cycle after that, to confirm the pulse has ended. It sweeps all sixteen opcodes, all four DC-precision codes and a grid of live status values, and predicts every field from the opcode and data arithmetic.

// File: rtl/dcmd_pkg.sv
package dcmd_pkg;

    localparam logic [7:0] REG_CMD  = 8'h00;
    localparam logic [7:0] REG_CTRL = 8'h10;
    localparam logic [7:0] REG_BP   = 8'h20;

    localparam int CTRL_RST_BIT = 30;

    typedef enum logic [3:0] {
        OP_BCLR  = 4'd0,
        OP_IDEC  = 4'd1,
        OP_BDEC  = 4'd2,
        OP_VDEC  = 4'd3,
        OP_FDEC  = 4'd4,
        OP_SETIQ = 4'd5,
        OP_SETVQ = 4'd6,
        OP_CSC   = 4'd7,
        OP_PACK  = 4'd8,
        OP_SETTH = 4'd9
    } opcode_e;

    typedef struct packed {
        logic known;
        logic inline_done;
        logic adv;
        logic top;
        logic data;
    } cmd_class_t;

    typedef struct packed {
        logic        busy;
        logic        top_busy;
        logic        data_busy;
        logic        end_flag;
        logic        sc_flag;
        logic [7:0]  cfg;
        logic [31:0] cmd;
        logic [7:0]  thr0;
        logic [7:0]  thr1;
        logic        irq;
        logic        fifo_clr;
        logic        bp_load;
        logic [6:0]  bp_val;
        logic        bp_adv;
        logic [5:0]  adv_bits;
        logic        soft_rst;
        logic        start;
    } fe_state_t;

endpackage

// File: rtl/dcmd_classify.sv
module dcmd_classify
    import dcmd_pkg::*;
(
    input  logic [3:0] opcode,
    output cmd_class_t cls
);
    always_comb begin
        cls = '0;
        case (opcode)
            OP_BCLR, OP_SETTH: begin
                cls.known       = 1'b1;
                cls.inline_done = 1'b1;
            end
            OP_IDEC, OP_BDEC: begin
                cls.known = 1'b1;
                cls.adv   = 1'b1;
                cls.top   = 1'b1;
            end
            OP_VDEC, OP_FDEC: begin
                cls.known = 1'b1;
                cls.adv   = 1'b1;
                cls.data  = 1'b1;
            end
            OP_SETIQ: begin
                cls.known = 1'b1;
                cls.adv   = 1'b1;
            end
            OP_SETVQ, OP_CSC, OP_PACK: begin
                cls.known = 1'b1;
            end
            default: cls = '0;
        endcase
    end
endmodule

// File: rtl/dcmd_readback.sv
module dcmd_readback
    import dcmd_pkg::*;
#(
    parameter int IFC_W = 4,
    parameter int CBP_W = 6
) (
    input  logic [7:0]       sel,
    input  logic [31:0]      cmd,
    input  logic             busy,
    input  logic             end_flag,
    input  logic             sc_flag,
    input  logic [7:0]       cfg,
    input  logic [6:0]       bp_off,
    input  logic [IFC_W-1:0] fifo_cnt,
    input  logic [1:0]       fill_ptr,
    input  logic [CBP_W-1:0] cbp,
    output logic [31:0]      data
);
    localparam int CBP_LSB  = 8;
    localparam int IFC_BPLSB = 8;
    localparam int FP_LSB   = 16;

    always_comb begin
        data = '0;
        case (sel)
            REG_CMD: data = cmd;
            REG_CTRL: begin
                data[IFC_W-1:0]           = fifo_cnt;
                data[CBP_LSB +: CBP_W]    = cbp;
                data[14]                  = end_flag;
                data[15]                  = sc_flag;
                data[23:16]               = cfg;
                data[31]                  = busy;
            end
            REG_BP: begin
                data[6:0]                 = bp_off;
                data[IFC_BPLSB +: IFC_W]  = fifo_cnt;
                data[FP_LSB +: 2]         = fill_ptr;
            end
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/dcmd_frontend.sv
module dcmd_frontend
    import dcmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IFC_W  = 4,
    parameter int CBP_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              eng_done,
    input  logic              eng_flag_end,
    input  logic              eng_flag_start,
    input  logic [6:0]        live_bp_off,
    input  logic [IFC_W-1:0]  live_fifo_cnt,
    input  logic [1:0]        live_fill_ptr,
    input  logic [CBP_W-1:0]  live_cbp,
    output logic              busy,
    output logic              top_busy,
    output logic              data_busy,
    output logic              irq,
    output logic              cmd_start,
    output logic [31:0]       cmd_word,
    output logic              fifo_clear,
    output logic              bp_load,
    output logic [6:0]        bp_load_val,
    output logic              bp_adv,
    output logic [5:0]        bp_adv_bits,
    output logic              soft_rst,
    output logic [7:0]        dec_cfg,
    output logic [7:0]        thresh0,
    output logic [7:0]        thresh1
);
    localparam int SEL_W = 8;

    fe_state_t  st_d, st_q;
    cmd_class_t cls;
    logic [SEL_W-1:0] wr_sel;
    logic [7:0]       cfg_wr;
    logic             unused_addr_hi;

    assign wr_sel = bus_addr[SEL_W-1:0];
    assign unused_addr_hi = ^{bus_addr[ADDR_W-1:SEL_W], rd_addr[ADDR_W-1:SEL_W]};

    // illegal DC-precision code 3 is folded onto 1
    assign cfg_wr = {bus_wdata[23:18],
                     (bus_wdata[17:16] == 2'b11) ? 2'b01 : bus_wdata[17:16]};

    dcmd_classify u_cls (
        .opcode (bus_wdata[31:28]),
        .cls    (cls)
    );

    always_comb begin
        st_d          = st_q;
        st_d.irq      = 1'b0;
        st_d.fifo_clr = 1'b0;
        st_d.bp_load  = 1'b0;
        st_d.bp_adv   = 1'b0;
        st_d.soft_rst = 1'b0;
        st_d.start    = 1'b0;

        if (eng_flag_end)   st_d.end_flag = 1'b1;
        if (eng_flag_start) st_d.sc_flag  = 1'b1;

        if (st_q.busy && eng_done) begin
            st_d.busy      = 1'b0;
            st_d.top_busy  = 1'b0;
            st_d.data_busy = 1'b0;
            st_d.cmd       = '1;
            st_d.irq       = 1'b1;
        end

        if (bus_wr) begin
            case (wr_sel)
                REG_CMD: begin
                    if (cls.known) begin
                        st_d.end_flag = 1'b0;
                        st_d.sc_flag  = 1'b0;
                        st_d.cmd      = bus_wdata;
                        if (cls.inline_done) begin
                            st_d.irq = 1'b1;
                            if (bus_wdata[31:28] == OP_BCLR) begin
                                st_d.fifo_clr  = 1'b1;
                                st_d.bp_load   = 1'b1;
                                st_d.bp_val    = bus_wdata[6:0];
                                st_d.busy      = 1'b0;
                                st_d.top_busy  = 1'b0;
                                st_d.data_busy = 1'b0;
                            end else begin
                                st_d.thr0 = bus_wdata[7:0];
                                st_d.thr1 = bus_wdata[23:16];
                            end
                        end else begin
                            st_d.busy      = 1'b1;
                            st_d.top_busy  = cls.top;
                            st_d.data_busy = cls.data;
                            st_d.start     = 1'b1;
                            st_d.irq       = 1'b0;
                            if (cls.adv) begin
                                st_d.bp_adv   = 1'b1;
                                st_d.adv_bits = bus_wdata[5:0];
                            end
                        end
                    end
                end
                REG_CTRL: begin
                    if (!bus_wide) begin
                        st_d.cfg = cfg_wr;
                        if (bus_wdata[CTRL_RST_BIT]) begin
                            st_d.cfg       = '0;
                            st_d.fifo_clr  = 1'b1;
                            st_d.bp_load   = 1'b1;
                            st_d.bp_val    = '0;
                            st_d.soft_rst  = 1'b1;
                            st_d.busy      = 1'b0;
                            st_d.top_busy  = 1'b0;
                            st_d.data_busy = 1'b0;
                            st_d.end_flag  = 1'b0;
                            st_d.sc_flag   = 1'b0;
                            st_d.cmd       = '1;
                            st_d.irq       = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cmd <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    dcmd_readback #(.IFC_W(IFC_W), .CBP_W(CBP_W)) u_rb (
        .sel      (rd_addr[SEL_W-1:0]),
        .cmd      (st_q.cmd),
        .busy     (st_q.busy),
        .end_flag (st_q.end_flag),
        .sc_flag  (st_q.sc_flag),
        .cfg      (st_q.cfg),
        .bp_off   (live_bp_off),
        .fifo_cnt (live_fifo_cnt),
        .fill_ptr (live_fill_ptr),
        .cbp      (live_cbp),
        .data     (rd_data)
    );

    assign busy        = st_q.busy;
    assign top_busy    = st_q.top_busy;
    assign data_busy   = st_q.data_busy;
    assign irq         = st_q.irq;
    assign cmd_start   = st_q.start;
    assign cmd_word    = st_q.cmd;
    assign fifo_clear  = st_q.fifo_clr;
    assign bp_load     = st_q.bp_load;
    assign bp_load_val = st_q.bp_val;
    assign bp_adv      = st_q.bp_adv;
    assign bp_adv_bits = st_q.adv_bits;
    assign soft_rst    = st_q.soft_rst;
    assign dec_cfg     = st_q.cfg;
    assign thresh0     = st_q.thr0;
    assign thresh1     = st_q.thr1;

endmodule

// File: rtl/dcmd_checker.sv
module dcmd_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_wide,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data,
    input logic              eng_done,
    input logic              busy,
    input logic              top_busy,
    input logic              data_busy,
    input logic              irq,
    input logic              fifo_clear,
    input logic              bp_load,
    input logic              soft_rst
);
    logic       cmd_wr;
    logic       ctrl_rst_wr;
    logic [3:0] op;

    assign op          = bus_wdata[31:28];
    assign cmd_wr      = bus_wr && (bus_addr[7:0] == 8'h00);
    assign ctrl_rst_wr = bus_wr && !bus_wide && (bus_addr[7:0] == 8'h10) && bus_wdata[30];

    a_r3_bclr_inline: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && op == 4'd0 |=> fifo_clear && bp_load && irq && !busy);

    a_r5_decode_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && op >= 4'd1 && op <= 4'd8 |=> busy && !irq);

    a_r5_sub_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (top_busy || data_busy) |-> busy);

    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        busy && eng_done && !bus_wr |=> !busy && irq);

    a_r7_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && eng_done && !bus_wr |=> !irq);

    a_r12_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && op >= 4'd10 && !busy |=> !busy && !irq && !fifo_clear);

    a_r8_no_bad_idp: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr[7:0] == 8'h10 |-> rd_data[17:16] != 2'b11);

    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rst_wr |=> soft_rst && fifo_clear && !busy && !irq);

endmodule

bind dcmd_frontend dcmd_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dcmd_frontend_test.sv
module dcmd_frontend_test;
    localparam int ADDR_W = 12;
    localparam int IFC_W  = 4;
    localparam int CBP_W  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_wide = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0, rd_addr = '0;
    logic [31:0] bus_wdata = '0, rd_data, cmd_word;
    logic eng_done = 1'b0, eng_flag_end = 1'b0, eng_flag_start = 1'b0;
    logic [6:0] live_bp_off = '0;
    logic [IFC_W-1:0] live_fifo_cnt = '0;
    logic [1:0] live_fill_ptr = '0;
    logic [CBP_W-1:0] live_cbp = '0;
    logic busy, top_busy, data_busy, irq, cmd_start, fifo_clear, bp_load, bp_adv, soft_rst;
    logic [6:0] bp_load_val;
    logic [5:0] bp_adv_bits;
    logic [7:0] dec_cfg, thresh0, thresh1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dcmd_frontend #(.ADDR_W(ADDR_W), .IFC_W(IFC_W), .CBP_W(CBP_W)) uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic wide);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = wide;
        @(negedge clk);
        bus_wr = 1'b0; bus_wide = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp_cmd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        chk("R2 busy", {31'd0, busy}, 32'd0);
        chk("R2 irq", {31'd0, irq}, 32'd0);
        rd(12'h000, v); chk("R2 cmd", v, 32'hFFFF_FFFF);
        rd(12'h010, v); chk("R2 ctrl", v, 32'd0);
        chk("R2 thresholds", {16'd0, thresh1, thresh0}, 32'd0);
        exp_cmd = 32'hFFFF_FFFF;

        // R3 R4 R5 R6 R7 R12 R14: sweep every opcode
        for (int op = 0; op < 16; op++) begin
            logic [31:0] w;
            logic known, inl, adv, tb, db;
            w = {op[3:0], 4'h0, 8'(16 * op + 1), 8'h00, 8'(op * 7 + 5)};
            known = (op <= 9);
            inl   = (op == 0) || (op == 9);
            adv   = (op >= 1) && (op <= 5);
            tb    = (op == 1) || (op == 2);
            db    = (op == 3) || (op == 4);
            eng_flag_end = 1'b1; eng_flag_start = 1'b1;
            @(negedge clk);
            eng_flag_end = 1'b0; eng_flag_start = 1'b0;
            rd(12'h010, v); chk("R6 flags set", {30'd0, v[15:14]}, 32'd3);
            wr(12'h000, w, 1'b0);
            if (known) exp_cmd = w;
            chk("R5 busy", {31'd0, busy}, {31'd0, known && !inl});
            chk("R5 cmd_start", {31'd0, cmd_start}, {31'd0, known && !inl});
            chk("R5 top_busy", {31'd0, top_busy}, {31'd0, tb});
            chk("R5 data_busy", {31'd0, data_busy}, {31'd0, db});
            chk("R5 bp_adv", {31'd0, bp_adv}, {31'd0, adv});
            if (adv) chk("R5 adv bits", {26'd0, bp_adv_bits}, {26'd0, w[5:0]});
            chk("R3 irq inline", {31'd0, irq}, {31'd0, inl});
            chk("R3 fifo_clear", {31'd0, fifo_clear}, {31'd0, op == 0});
            chk("R3 bp_load", {31'd0, bp_load}, {31'd0, op == 0});
            if (op == 0) chk("R3 load value", {25'd0, bp_load_val}, {25'd0, w[6:0]});
            if (op == 9) chk("R4 thresholds", {16'd0, thresh1, thresh0}, {16'd0, w[23:16], w[7:0]});
            rd(12'h010, v); chk("R6 R12 flags after write", {30'd0, v[15:14]}, known ? 32'd0 : 32'd3);
            rd(12'h000, v); chk("R12 cmd register", v, exp_cmd);
            @(negedge clk);
            chk("R14 irq one cycle", {31'd0, irq}, 32'd0);
            if (known && !inl) begin
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
                chk("R7 busy cleared", {29'd0, busy, top_busy, data_busy}, 32'd0);
                chk("R7 irq", {31'd0, irq}, 32'd1);
                exp_cmd = 32'hFFFF_FFFF;
                rd(12'h000, v); chk("R7 cmd all ones", v, exp_cmd);
            end
        end

        // R7 done while idle
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        chk("R7 idle done no irq", {31'd0, irq}, 32'd0);

        // R8 DC-precision sweep, R1 aliasing via upper address bits
        for (int k = 0; k < 4; k++) begin
            logic [7:0] c;
            c = {6'(k * 5 + 1), 2'(k)};
            wr(12'h710 + 12'(k * 256) & 12'hFFF, {8'h00, c, 16'h0000}, 1'b0);
            rd(12'h310, v);
            chk("R8 R1 cfg stored", {24'd0, v[23:16]}, {24'd0, c[7:2], (k == 3) ? 2'b01 : c[1:0]});
            chk("R8 dec_cfg", {24'd0, dec_cfg}, {24'd0, c[7:2], (k == 3) ? 2'b01 : c[1:0]});
        end

        // R13 wide control write ignored
        rd(12'h010, v);
        wr(12'h010, 32'h00AA_0000, 1'b1);
        begin
            logic [31:0] v2;
            rd(12'h010, v2); chk("R13 wide ctrl ignored", v2, v);
        end
        // R1 unmapped offset write and read
        wr(12'h030, 32'h00FF_0000, 1'b0);
        rd(12'h010, v); chk("R1 unmapped write no effect", {24'd0, v[23:16]}, {24'd0, 6'd16, 2'd3 == 3 ? 2'b01 : 2'b00});
        rd(12'h030, v); chk("R1 unmapped read zero", v, 32'd0);
        // R13 wide command write uses low word
        wr(12'h100, 32'h9012_0034, 1'b1);
        chk("R13 wide cmd thresholds", {16'd0, thresh1, thresh0}, 32'h0000_1234);
        rd(12'h000, v); chk("R13 wide cmd word", v, 32'h9012_0034);

        // R10 bit-pointer readback, R11 control readback
        for (int f = 0; f < 3; f++) begin
            for (int n = 0; n < 16; n += 5) begin
                live_bp_off = 7'(n * 8 + f);
                live_fifo_cnt = IFC_W'(n);
                live_fill_ptr = 2'(f);
                live_cbp = CBP_W'(n * 3 + f);
                rd(12'h020, v);
                chk("R10 bp readback", v, (32'(f) << 16) | (32'(n) << 8) | 32'(n * 8 + f));
                rd(12'h010, v);
                chk("R11 ctrl live fields", {16'd0, v[15:0]}, (32'((n * 3 + f) & 63) << 8) | 32'(n));
            end
        end
        live_bp_off = '0; live_fifo_cnt = '0; live_fill_ptr = '0; live_cbp = '0;

        // R9 soft reset while busy
        wr(12'h000, 32'h1000_0003, 1'b0);
        chk("R9 pre busy", {31'd0, busy}, 32'd1);
        wr(12'h010, 32'h4007_0000, 1'b0);
        chk("R9 busy cleared", {29'd0, busy, top_busy, data_busy}, 32'd0);
        chk("R9 pulses", {29'd0, fifo_clear, bp_load, soft_rst}, 32'd7);
        chk("R9 load zero", {25'd0, bp_load_val}, 32'd0);
        chk("R9 no irq", {31'd0, irq}, 32'd0);
        rd(12'h010, v); chk("R9 ctrl cleared", v, 32'd0);
        rd(12'h000, v); chk("R9 cmd all ones", v, 32'hFFFF_FFFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule